// File: doc/BRIEF.md
# Synthesizer Load Sequencer

This block runs in the host clock domain and programs a direct-digital frequency synthesizer through its narrow load port. The host hands over one request: a 32-bit tuning word, a 5-bit phase offset, a power-down flag and an operation code. The sequencer then drives the synthesizer's 8-bit data bus, its word-load clock, its update strobe and its master reset. Every pulse width and edge spacing is generated from parameters given in picoseconds, which are turned into host-cycle counts rounded up.

A 40-bit frame is assembled as `{phase[4:0], pd, 2'b00, tw[31:0]}`. In byte mode the frame goes out as five bytes, most significant byte first. In bit mode it goes out one bit per load on bus bit 7, least significant bit first. The first bit-mode transfer after reset, and the first one after a master-reset operation, is preceded by a one-byte switch-over sequence. A master-reset operation drives the reset line for a whole number of reference-clock periods. The sequencer takes one request at a time. It shows `busy_o` while it works and pulses `done_o` once at the end.

Top module: `dds_prog_seq`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it rises, `dds_data_o`, `dds_wclk_o`, `dds_fqud_o`, `dds_rst_o`, `busy_o` and `done_o` are all 0.
- R2: With `req_op_i` = 2'b00 (byte mode), exactly five bytes are latched, one at each rising edge of `dds_wclk_o`, in this order: `{phase, pd, 2'b00}`, `tw[31:24]`, `tw[23:16]`, `tw[15:8]`, `tw[7:0]`. The two low bits of the first byte are always 0.
- R3: With `req_op_i` = 2'b01 (bit mode), exactly 40 loads are made. Load i carries frame bit i on `dds_data_o[7]`, and bits 6:0 are 0. Bits 0–31 are `tw`, bits 32–33 are 0, bit 34 is `pd`, and bits 35–39 are `phase`.
- R4: The first bit-mode request after reset, or after a master-reset operation, is preceded by one load of byte 8'h03 and one update pulse. Later bit-mode requests do not have this preamble.
- R5: Every byte-mode or bit-mode frame is followed by exactly one `dds_fqud_o` pulse. No other update pulse is issued, apart from the R4 preamble pulse.
- R6: `dds_wclk_o` stays high for at least HI_CYC cycles and low for at least LO_CYC cycles before each rise. `dds_data_o` does not change while `dds_wclk_o` is high. Here HI_CYC = max(ceil(WCLK_HI_PS/HOST_PS), ceil(HOLD_PS/HOST_PS)) and LO_CYC = max(ceil(WCLK_LO_PS/HOST_PS), ceil(SETUP_PS/HOST_PS)).
- R7: `dds_fqud_o` stays high for at least ceil(UPD_HI_PS/HOST_PS) cycles. It rises only after `dds_wclk_o` has been low for at least GAP_CYC = max(ceil(UPD_DLY_PS/HOST_PS), ceil(UPD_LO_PS/HOST_PS)) cycles. After it falls, it stays low for at least ceil(UPD_LO_PS/HOST_PS) cycles before the next `dds_wclk_o` rise. It is never high together with `dds_wclk_o`.
- R8: With `req_op_i[1]` = 1 (master reset), `dds_rst_o` is high for exactly ceil(RST_REF_CYC*REF_PS/HOST_PS) cycles. No word-load edge and no update pulse are issued.
- R9: A request is taken only when `req_valid_i` is high while `busy_o` is low. `busy_o` is high from the next cycle until the operation ends. A request raised while busy has no effect.
- R10: `done_o` is high for exactly one cycle per accepted request, in the first cycle where `busy_o` is low again. This is after the update strobe has been low for its minimum time, or after reset falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_op_i | input | 2 | 00 byte mode, 01 bit mode, 1x master reset |
| req_tw_i | input | 32 | Frequency tuning word |
| req_phase_i | input | 5 | Phase offset |
| req_pd_i | input | 1 | Power-down flag |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| dds_data_o | output | 8 | Synthesizer data bus |
| dds_wclk_o | output | 1 | Word-load clock |
| dds_fqud_o | output | 1 | Update strobe |
| dds_rst_o | output | 1 | Master reset |

## Verification
The bench records every byte latched at a rising edge of the word-load clock. It rebuilds the frame from these bytes and compares it with the frame expected from the request, so a wrong step index or a wrong frame order shows up at the first bad load.

A serial-mode flag held in the wrong state shows up as one byte too many or too few and one update pulse too many or too few, already in the next bit-mode request. A timer loaded with the wrong value shows up as a pulse shorter than its minimum in the next sequence, or as a wrong reset width.

// File: rtl/dds_seq_pkg.sv
package dds_seq_pkg;
  localparam int unsigned TW_W    = 32;
  localparam int unsigned PH_W    = 5;
  localparam int unsigned CTL_W   = 2;
  localparam int unsigned BUS_W   = 8;
  localparam int unsigned FRAME_W = PH_W + 1 + CTL_W + TW_W;
  localparam int unsigned NBYTES  = FRAME_W / BUS_W;
  localparam int unsigned IDX_W   = $clog2(FRAME_W);
  localparam logic [BUS_W-1:0] SER_EN_BYTE = 8'h03;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LO, ST_HI, ST_GAP, ST_UPD_HI, ST_UPD_LO, ST_RST
  } seq_state_e;

  function automatic int unsigned to_cyc(input longint unsigned ps, input longint unsigned clk_ps);
    longint unsigned c;
    c = (ps + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : int'(c);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dds_seq_timer.sv
module dds_seq_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/dds_seq_frame.sv
module dds_seq_frame
  import dds_seq_pkg::*;
(
  input  logic [TW_W-1:0]  tw_i,
  input  logic [PH_W-1:0]  phase_i,
  input  logic             pd_i,
  input  logic             serial_i,
  input  logic             pre_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [BUS_W-1:0] byte_o
);
  logic [FRAME_W-1:0] word;
  logic [BUS_W-1:0]   par_bytes [NBYTES];
  logic               ser_bit;

  // control field forced to zero: reserved codes never leave the block
  assign word = {phase_i, pd_i, {CTL_W{1'b0}}, tw_i};

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    assign par_bytes[k] = word[FRAME_W-1-BUS_W*k -: BUS_W];
  end

  assign ser_bit = (int'(idx_i) < FRAME_W) ? word[idx_i] : 1'b0;

  always_comb begin
    if (pre_i)                      byte_o = SER_EN_BYTE;
    else if (serial_i)              byte_o = {ser_bit, {(BUS_W-1){1'b0}}};
    else if (int'(idx_i) < NBYTES)  byte_o = par_bytes[idx_i[$clog2(NBYTES)-1:0]];
    else                            byte_o = '0;
  end
endmodule

// File: rtl/dds_prog_seq.sv
module dds_prog_seq
  import dds_seq_pkg::*;
#(
  parameter int unsigned HOST_PS     = 10000,
  parameter int unsigned WCLK_HI_PS  = 3500,
  parameter int unsigned WCLK_LO_PS  = 3500,
  parameter int unsigned SETUP_PS    = 3500,
  parameter int unsigned HOLD_PS     = 3500,
  parameter int unsigned UPD_HI_PS   = 7000,
  parameter int unsigned UPD_LO_PS   = 7000,
  parameter int unsigned UPD_DLY_PS  = 7000,
  parameter int unsigned REF_PS      = 8000,
  parameter int unsigned RST_REF_CYC = 5,
  parameter int unsigned CNT_W       = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [1:0]       req_op_i,
  input  logic [TW_W-1:0]  req_tw_i,
  input  logic [PH_W-1:0]  req_phase_i,
  input  logic             req_pd_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [BUS_W-1:0] dds_data_o,
  output logic             dds_wclk_o,
  output logic             dds_fqud_o,
  output logic             dds_rst_o
);
  localparam int unsigned LO_CYC  = max2(to_cyc(WCLK_LO_PS, HOST_PS), to_cyc(SETUP_PS, HOST_PS));
  localparam int unsigned HI_CYC  = max2(to_cyc(WCLK_HI_PS, HOST_PS), to_cyc(HOLD_PS, HOST_PS));
  localparam int unsigned GAP_CYC = max2(to_cyc(UPD_DLY_PS, HOST_PS), to_cyc(UPD_LO_PS, HOST_PS));
  localparam int unsigned FH_CYC  = to_cyc(UPD_HI_PS, HOST_PS);
  localparam int unsigned FL_CYC  = to_cyc(UPD_LO_PS, HOST_PS);
  localparam int unsigned RST_CYC = to_cyc(longint'(RST_REF_CYC) * REF_PS, HOST_PS);

  localparam logic [CNT_W-1:0] LO_V  = CNT_W'(LO_CYC - 1);
  localparam logic [CNT_W-1:0] HI_V  = CNT_W'(HI_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_V = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] FH_V  = CNT_W'(FH_CYC - 1);
  localparam logic [CNT_W-1:0] FL_V  = CNT_W'(FL_CYC - 1);
  localparam logic [CNT_W-1:0] RST_V = CNT_W'(RST_CYC - 1);
  localparam logic [IDX_W-1:0] SER_LAST = IDX_W'(FRAME_W - 1);
  localparam logic [IDX_W-1:0] PAR_LAST = IDX_W'(NBYTES - 1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d, last_idx;
  logic             pre_q, pre_d, ser_en_q, ser_en_d, done_q, done_d;
  logic             accept, tmr_load, tmr_exp;
  logic [CNT_W-1:0] tmr_val;
  logic [1:0]       op_q;
  logic [TW_W-1:0]  tw_q;
  logic [PH_W-1:0]  phase_q;
  logic             pd_q;
  logic [BUS_W-1:0] frame_byte;

  assign last_idx = pre_q ? '0 : (op_q[0] ? SER_LAST : PAR_LAST);

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    pre_d    = pre_q;
    ser_en_d = ser_en_q;
    done_d   = 1'b0;
    accept   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        accept   = 1'b1;
        tmr_load = 1'b1;
        idx_d    = '0;
        if (req_op_i[1]) begin
          state_d = ST_RST;
          tmr_val = RST_V;
        end else begin
          state_d = ST_LO;
          tmr_val = LO_V;
          pre_d   = req_op_i[0] && !ser_en_q;
        end
      end
      ST_LO: if (tmr_exp) begin
        state_d = ST_HI; tmr_load = 1'b1; tmr_val = HI_V;
      end
      ST_HI: if (tmr_exp) begin
        tmr_load = 1'b1;
        if (idx_q == last_idx) begin
          state_d = ST_GAP; tmr_val = GAP_V;
        end else begin
          idx_d = idx_q + 1'b1; state_d = ST_LO; tmr_val = LO_V;
        end
      end
      ST_GAP: if (tmr_exp) begin
        state_d = ST_UPD_HI; tmr_load = 1'b1; tmr_val = FH_V;
      end
      ST_UPD_HI: if (tmr_exp) begin
        state_d = ST_UPD_LO; tmr_load = 1'b1; tmr_val = FL_V;
      end
      ST_UPD_LO: if (tmr_exp) begin
        if (pre_q) begin
          // preamble done: device now in bit mode, start the real frame
          pre_d = 1'b0; ser_en_d = 1'b1; idx_d = '0;
          state_d = ST_LO; tmr_load = 1'b1; tmr_val = LO_V;
        end else begin
          state_d = ST_IDLE; done_d = 1'b1;
        end
      end
      ST_RST: if (tmr_exp) begin
        state_d = ST_IDLE; done_d = 1'b1; ser_en_d = 1'b0;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      pre_q    <= 1'b0;
      ser_en_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      pre_q    <= pre_d;
      ser_en_q <= ser_en_d;
      done_q   <= done_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q <= '0; tw_q <= '0; phase_q <= '0; pd_q <= 1'b0;
    end else if (accept) begin
      op_q <= req_op_i; tw_q <= req_tw_i; phase_q <= req_phase_i; pd_q <= req_pd_i;
    end
  end

  dds_seq_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .val_i     (tmr_val),
    .expired_o (tmr_exp)
  );

  dds_seq_frame i_frame (
    .tw_i     (tw_q),
    .phase_i  (phase_q),
    .pd_i     (pd_q),
    .serial_i (op_q[0]),
    .pre_i    (pre_q),
    .idx_i    (idx_q),
    .byte_o   (frame_byte)
  );

  always_comb begin
    unique case (state_q)
      ST_LO, ST_HI, ST_GAP, ST_UPD_HI, ST_UPD_LO: dds_data_o = frame_byte;
      default:                                    dds_data_o = '0;
    endcase
  end

  assign dds_wclk_o = (state_q == ST_HI);
  assign dds_fqud_o = (state_q == ST_UPD_HI);
  assign dds_rst_o  = (state_q == ST_RST);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
endmodule

// File: rtl/dds_seq_checker.sv
module dds_seq_checker #(
  parameter int unsigned HI_CYC  = 1,
  parameter int unsigned LO_CYC  = 1,
  parameter int unsigned GAP_CYC = 1,
  parameter int unsigned FH_CYC  = 1,
  parameter int unsigned FL_CYC  = 1,
  parameter int unsigned RST_CYC = 1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_o,
  input logic       done_o,
  input logic [7:0] dds_data_o,
  input logic       dds_wclk_o,
  input logic       dds_fqud_o,
  input logic       dds_rst_o
);
  logic [15:0] w_hi, w_lo, f_hi, f_lo, r_hi;

  function automatic logic [15:0] step(input logic [15:0] v, input logic on);
    return on ? ((v == 16'hFFFF) ? v : v + 16'd1) : 16'd0;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_hi <= '0; w_lo <= '0; f_hi <= '0; f_lo <= '0; r_hi <= '0;
    end else begin
      w_hi <= step(w_hi, dds_wclk_o);
      w_lo <= step(w_lo, !dds_wclk_o);
      f_hi <= step(f_hi, dds_fqud_o);
      f_lo <= step(f_lo, !dds_fqud_o);
      r_hi <= step(r_hi, dds_rst_o);
    end
  end

  assert_wclk_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dds_wclk_o) |-> w_hi >= 16'(HI_CYC));
  assert_wclk_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dds_wclk_o) |-> w_lo >= 16'(LO_CYC));
  assert_data_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dds_wclk_o |-> $stable(dds_data_o));
  assert_fqud_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dds_fqud_o) |-> w_lo >= 16'(GAP_CYC));
  assert_fqud_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dds_fqud_o) |-> f_hi >= 16'(FH_CYC));
  assert_fqud_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dds_wclk_o) |-> f_lo >= 16'(FL_CYC));
  assert_no_overlap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dds_wclk_o && dds_fqud_o));
  assert_reset_width_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dds_rst_o) |-> r_hi == 16'(RST_CYC));
  assert_reset_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dds_rst_o |-> !dds_wclk_o && !dds_fqud_o);
  assert_busy_cover_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dds_wclk_o || dds_fqud_o || dds_rst_o) |-> busy_o);
  assert_done_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $fell(busy_o));
endmodule

bind dds_prog_seq dds_seq_checker #(
  .HI_CYC(HI_CYC), .LO_CYC(LO_CYC), .GAP_CYC(GAP_CYC),
  .FH_CYC(FH_CYC), .FL_CYC(FL_CYC), .RST_CYC(RST_CYC)
) i_dds_seq_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .dds_data_o(dds_data_o), .dds_wclk_o(dds_wclk_o),
  .dds_fqud_o(dds_fqud_o), .dds_rst_o(dds_rst_o)
);

// File: tb/test_dds_prog_seq.sv
`timescale 1ns/1ps
module test_dds_prog_seq;
  // expected cycle counts at 10 ns host clock with the overrides below
  localparam int E_LO = 2, E_HI = 3, E_GAP = 3, E_FH = 4, E_FL = 3, E_RST = 6;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_pd = 1'b0;
  logic [1:0]  req_op = '0;
  logic [31:0] req_tw = '0;
  logic [4:0]  req_phase = '0;
  logic        busy, done, wclk, fqud, drst;
  logic [7:0]  data;

  always #5 clk = ~clk;

  dds_prog_seq #(
    .HOST_PS(10000), .WCLK_HI_PS(25000), .WCLK_LO_PS(15000), .SETUP_PS(3500),
    .HOLD_PS(3500), .UPD_HI_PS(40000), .UPD_LO_PS(30000), .UPD_DLY_PS(7000),
    .REF_PS(8000), .RST_REF_CYC(7)
  ) i_dds_prog_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_tw_i(req_tw), .req_phase_i(req_phase), .req_pd_i(req_pd),
    .busy_o(busy), .done_o(done), .dds_data_o(data), .dds_wclk_o(wclk),
    .dds_fqud_o(fqud), .dds_rst_o(drst)
  );

  int checks = 0, errors = 0;
  logic [7:0] cap [256];
  int ncap = 0, nupd = 0, ndone = 0;
  int wh_len = 0, wl_len = 0, fh_len = 0, fl_len = 0, r_len = 0, d_len = 0;
  int min_whi = 9999, min_wlo = 9999, min_fh = 9999, min_gap = 9999, min_fl = 9999;
  int max_d = 0, stab_viol = 0, last_rst = 0, overlap = 0;
  bit prev_w = 0, prev_f = 0, prev_r = 0, f_seen = 0;
  logic [7:0] rise_data = '0;
  int b_cap, b_upd, b_done;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_w = 0; prev_f = 0; prev_r = 0; wh_len = 0; wl_len = 0; fh_len = 0; fl_len = 0;
      r_len = 0; d_len = 0;
    end else begin
      if (wclk && !prev_w) begin
        if (ncap < 256) cap[ncap] = data;
        ncap++;
        if (wl_len < min_wlo) min_wlo = wl_len;
        if (f_seen && fl_len < min_fl) min_fl = fl_len;
        rise_data = data;
      end
      if (wclk && data != rise_data) stab_viol++;
      if (wclk && fqud) overlap++;
      if (!wclk && prev_w && wh_len < min_whi) min_whi = wh_len;
      if (fqud && !prev_f) begin
        nupd++;
        if (wl_len < min_gap) min_gap = wl_len;
      end
      if (!fqud && prev_f) begin
        if (fh_len < min_fh) min_fh = fh_len;
        f_seen = 1;
      end
      if (!drst && prev_r) last_rst = r_len;
      if (done) begin
        if (d_len == 0) ndone++;
        d_len++;
        if (d_len > max_d) max_d = d_len;
      end else d_len = 0;
      wh_len = wclk ? wh_len + 1 : 0;
      wl_len = wclk ? 0 : wl_len + 1;
      fh_len = fqud ? fh_len + 1 : 0;
      fl_len = fqud ? 0 : fl_len + 1;
      r_len  = drst ? r_len + 1 : 0;
      prev_w = wclk; prev_f = fqud; prev_r = drst;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] frame(input logic [31:0] tw, input logic [4:0] ph, input logic pd);
    return {ph, pd, 2'b00, tw};
  endfunction

  task automatic run_req(input logic [1:0] op, input logic [31:0] tw, input logic [4:0] ph,
                         input logic pd);
    @(posedge clk); #1;
    b_cap = ncap; b_upd = nupd; b_done = ndone;
    req_valid = 1'b1; req_op = op; req_tw = tw; req_phase = ph; req_pd = pd;
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk(busy == 1'b1, "R9 busy after accept", busy, 1);
    while (ndone == b_done) @(posedge clk);
    repeat (4) @(posedge clk);
    #1;
  endtask

  // check captured bytes of one frame starting at cap index base
  task automatic chk_frame(input int base, input logic [1:0] op, input logic [39:0] f);
    int bad = 0;
    logic [7:0] e = '0, a = '0;
    if (op == 2'b00) begin
      for (int k = 0; k < 5; k++)
        if (cap[base+k] !== f[39-8*k -: 8] && bad == 0) begin
          bad = 1; a = cap[base+k]; e = f[39-8*k -: 8];
        end
      chk(bad == 0, "R2 byte order", a, e);
    end else begin
      for (int i = 0; i < 40; i++)
        if (cap[base+i] !== {f[i], 7'b0} && bad == 0) begin
          bad = 1; a = cap[base+i]; e = {f[i], 7'b0};
        end
      chk(bad == 0, "R3 bit order", a, e);
    end
  endtask

  // {phase[39:35], pd[34], op[33:32], tw[31:0]}
  localparam logic [39:0] VEC [4] = '{
    {5'h13, 1'b0, 2'b00, 32'h1234_5678},
    {5'h0A, 1'b1, 2'b01, 32'h8000_0001},
    {5'h1F, 1'b0, 2'b01, 32'hA5C3_0F96},
    {5'h01, 1'b1, 2'b00, 32'hFFFF_0000}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk({data, wclk, fqud, drst, busy, done} == '0, "R1 in reset", {data, wclk, fqud, drst, busy, done}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk({data, wclk, fqud, drst, busy, done} == '0, "R1 after reset", {data, wclk, fqud, drst, busy, done}, 0);

    for (int v = 0; v < 4; v++) begin
      logic [1:0] op;
      logic [39:0] f;
      int off, exp_cap, exp_upd;
      op = VEC[v][33:32];
      f  = frame(VEC[v][31:0], VEC[v][39:35], VEC[v][34]);
      run_req(op, VEC[v][31:0], VEC[v][39:35], VEC[v][34]);
      off = (v == 1) ? 1 : 0;  // first bit-mode request carries the preamble
      exp_cap = (op == 2'b00 ? 5 : 40) + off;
      exp_upd = 1 + off;
      chk(ncap - b_cap == exp_cap, op == 2'b00 ? "R2 load count" : "R3 load count", ncap - b_cap, exp_cap);
      chk(nupd - b_upd == exp_upd, "R5 update count", nupd - b_upd, exp_upd);
      if (off == 1) chk(cap[b_cap] == 8'h03, "R4 preamble byte", cap[b_cap], 8'h03);
      if (v == 2) chk(cap[b_cap] == {f[0], 7'b0}, "R4 no second preamble", cap[b_cap], {f[0], 7'b0});
      chk_frame(b_cap + off, op, f);
      chk(ndone - b_done == 1, "R10 one done", ndone - b_done, 1);
    end

    // request while busy is dropped
    @(posedge clk); #1;
    b_cap = ncap; b_upd = nupd; b_done = ndone;
    req_valid = 1'b1; req_op = 2'b00; req_tw = 32'hCAFE_F00D; req_phase = 5'h04; req_pd = 1'b0;
    @(posedge clk); #1;
    req_valid = 1'b0;
    repeat (3) @(posedge clk); #1;
    req_valid = 1'b1; req_op = 2'b01; req_tw = 32'h0BAD_0BAD; req_phase = 5'h1E;
    @(posedge clk); #1;
    req_valid = 1'b0;
    while (ndone == b_done) @(posedge clk);
    repeat (30) @(posedge clk); #1;
    chk(ncap - b_cap == 5, "R9 busy request ignored", ncap - b_cap, 5);
    chk(nupd - b_upd == 1, "R9 no extra update", nupd - b_upd, 1);
    chk(busy == 1'b0, "R9 idle after run", busy, 0);
    chk_frame(b_cap, 2'b00, frame(32'hCAFE_F00D, 5'h04, 1'b0));

    // master reset
    run_req(2'b10, 32'hFFFF_FFFF, 5'h1F, 1'b1);
    chk(last_rst == E_RST, "R8 reset width", last_rst, E_RST);
    chk(ncap == b_cap && nupd == b_upd, "R8 no loads", ncap - b_cap, 0);
    chk(ndone - b_done == 1, "R10 done after reset", ndone - b_done, 1);

    // bit mode again needs the preamble
    run_req(2'b01, 32'h0000_00FF, 5'h10, 1'b0);
    chk(ncap - b_cap == 41, "R4 preamble after reset", ncap - b_cap, 41);
    chk(cap[b_cap] == 8'h03, "R4 preamble byte again", cap[b_cap], 8'h03);
    chk(nupd - b_upd == 2, "R5 update count with preamble", nupd - b_upd, 2);
    chk_frame(b_cap + 1, 2'b01, frame(32'h0000_00FF, 5'h10, 1'b0));

    // timing minima seen over the whole run
    chk(min_whi >= E_HI, "R6 wclk high", min_whi, E_HI);
    chk(min_wlo >= E_LO, "R6 wclk low", min_wlo, E_LO);
    chk(stab_viol == 0, "R6 data stable", stab_viol, 0);
    chk(min_gap >= E_GAP, "R7 update gap", min_gap, E_GAP);
    chk(min_fh >= E_FH, "R7 update high", min_fh, E_FH);
    chk(min_fl >= E_FL, "R7 update low", min_fl, E_FL);
    chk(overlap == 0, "R7 no overlap", overlap, 0);
    chk(max_d == 1, "R10 done width", max_d, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule